// File: doc/BRIEF.md
# Parallel I/O Port Controller with Port-A Handshake

This block gives a host three byte-wide general-purpose ports (A, B, C) and a narrow auxiliary port D. It sits behind a byte bus with a 2-bit register select and single-cycle read and write strobes. Each port drives an output value and a per-bit output-enable vector, so the pad ring can build tristate pins from them.

One control register sets every direction. Port A can also run a strobed handshake. In that mode its buffer-full, acknowledge, strobe and interrupt lines use dedicated pins, so all eight bits of port C stay general-purpose I/O. Port D has no register of its own. Its two halves copy direction and drive value from the two nibbles of port C.

All handshake inputs are sampled on the clock. Edge detection compares each input with its registered value from the previous cycle. `rdata` is combinational from `addr` and the current state.

Top module: `pio_ctrl`

## Requirements
- R1: Register select 0, 1, 2 and 3 reach port A, port B, port C and the control register. Each can be written with `wr` and read on `rdata`. A control read returns bit 7 as 1 and bits 6..0 as stored.
- R2: After reset every port is an input in simple mode: all `*_oe` are 0, all output latches are 0, a control read gives 0x9B, `ibf`=0, `obf_n`=1 and `intr`=0.
- R3: A control write with bit 7 = 1 is a mode set. Bits 6..5 give the port A mode, and 01 means handshake. Bit 4 = 1 makes port A an input. Bit 3 = 1 makes C[7:4] an input. Bit 1 = 1 makes port B an input. Bit 0 = 1 makes C[3:0] an input. From the next cycle, a mode set clears all output latches, `ibf`, `intr` and the interrupt enable, and sets `obf_n`=1.
- R4: Reading a port (or port C nibble) set as output returns its latch. Reading one set as input returns its pins. An output port drives its latch, with all enables at 1.
- R5: A control write with bit 7 = 0 and bit 6 = 0 sets bit `wdata[3:1]` of the port C latch to `wdata[0]`. The stored mode and all directions stay unchanged.
- R6: Control bit 2 (port B mode) is ignored. It always reads back 0, and port B keeps simple I/O.
- R7: Port A mode codes 10 and 11 act like code 00: simple I/O, with no handshake activity.
- R8: `pd_oe`/`pd_out` low bits follow the direction of C[3:0] and the value of C latch [3:0]. The high bits follow the direction of C[7:4] and the value of C latch [5:4].
- R9: A control write with bit 7 = 0 and bit 6 = 1 sets the port A interrupt enable to `wdata[0]` and leaves the port C latch unchanged.
- R10: In handshake input mode, each cycle with `stb_n` low copies `pa_in` into an input holding register and sets `ibf`. A port A read returns the held value, not the pins.
- R11: In handshake input mode, a rising `stb_n` sets `intr` when the enable is 1. A port A read clears `intr` and `ibf`.
- R12: In handshake output mode, a port A write drives `obf_n` low and clears `intr`. A rising `ack_n` sets `obf_n` high and sets `intr` when the enable is 1.
- R13: In either handshake mode, all eight port C bits keep working as general-purpose I/O per R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select |
| wr | input | 1 | Write strobe, one cycle |
| rd | input | 1 | Read strobe, one cycle (acknowledges port A input) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C drive value |
| pc_oe | output | 8 | Port C output enables |
| pd_out | output | AUX_LO+AUX_HI | Port D drive value |
| pd_oe | output | AUX_LO+AUX_HI | Port D output enables |
| stb_n | input | 1 | Handshake input strobe, active low |
| ibf | output | 1 | Input buffer full |
| ack_n | input | 1 | Handshake output acknowledge, active low |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Port A interrupt request |

## Verification
The bench uses the defaults AUX_LO=4 and AUX_HI=2. With these, port D has a full low nibble and a two-bit high part, so the bench can watch both the nibble-wide and the partial-nibble mapping from port C. Random mode sets cover every direction combination, the ignored group B mode bit and the unsupported port A codes. Directed sequences drive the strobe and acknowledge edges with the interrupt enable both on and off.

// File: rtl/pio_ctrl.sv
module pio_ctrl #(
  parameter int AUX_LO = 4,
  parameter int AUX_HI = 2,
  localparam int AUX_W = AUX_LO + AUX_HI
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [7:0]       pa_in,
  output logic [7:0]       pa_out,
  output logic [7:0]       pa_oe,
  input  logic [7:0]       pb_in,
  output logic [7:0]       pb_out,
  output logic [7:0]       pb_oe,
  input  logic [7:0]       pc_in,
  output logic [7:0]       pc_out,
  output logic [7:0]       pc_oe,
  output logic [AUX_W-1:0] pd_out,
  output logic [AUX_W-1:0] pd_oe,
  input  logic             stb_n,
  output logic             ibf,
  input  logic             ack_n,
  output logic             obf_n,
  output logic             intr
);

  localparam logic [6:0] CTRL_RST = 7'b0011011;

  logic [6:0] ctrl;
  logic [7:0] lat_a, lat_b, lat_c, hold_a;
  logic       inte, stb_q, ack_q;

  wire a_in  = ctrl[4];
  wire ch_in = ctrl[3];
  wire b_in  = ctrl[1];
  wire cl_in = ctrl[0];
  wire hs    = (ctrl[6:5] == 2'b01);
  wire hs_in  = hs & a_in;
  wire hs_out = hs & ~a_in;
  wire rd_a  = rd & (addr == 2'd0);
  wire wr_a  = wr & (addr == 2'd0);
  wire stb_rise = stb_n & ~stb_q;
  wire ack_rise = ack_n & ~ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= CTRL_RST;
      lat_a  <= '0;
      lat_b  <= '0;
      lat_c  <= '0;
      hold_a <= '0;
      inte   <= 1'b0;
      ibf    <= 1'b0;
      obf_n  <= 1'b1;
      intr   <= 1'b0;
      stb_q  <= 1'b1;
      ack_q  <= 1'b1;
    end else begin
      stb_q <= stb_n;
      ack_q <= ack_n;
      if (hs_in) begin
        if (rd_a) begin
          ibf  <= 1'b0;
          intr <= 1'b0;
        end
        if (!stb_n) begin
          hold_a <= pa_in;
          ibf    <= 1'b1;
        end
        if (stb_rise && inte) intr <= 1'b1;
      end
      if (hs_out) begin
        if (wr_a) begin
          obf_n <= 1'b0;
          intr  <= 1'b0;
        end
        if (ack_rise) begin
          obf_n <= 1'b1;
          if (inte) intr <= 1'b1;
        end
      end
      if (wr) begin
        unique case (addr)
          2'd0: lat_a <= wdata;
          2'd1: lat_b <= wdata;
          2'd2: lat_c <= wdata;
          default: begin
            if (wdata[7]) begin
              ctrl  <= {wdata[6:3], 1'b0, wdata[1:0]};
              lat_a <= '0;
              lat_b <= '0;
              lat_c <= '0;
              inte  <= 1'b0;
              ibf   <= 1'b0;
              obf_n <= 1'b1;
              intr  <= 1'b0;
            end else if (wdata[6]) begin
              inte <= wdata[0];
            end else begin
              lat_c[wdata[3:1]] <= wdata[0];
            end
          end
        endcase
      end
    end
  end

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pc_out = lat_c;
  assign pa_oe  = {8{~a_in}};
  assign pb_oe  = {8{~b_in}};
  assign pc_oe  = {{4{~ch_in}}, {4{~cl_in}}};
  assign pd_out = {lat_c[4 +: AUX_HI], lat_c[0 +: AUX_LO]};
  assign pd_oe  = {{AUX_HI{~ch_in}}, {AUX_LO{~cl_in}}};

  always_comb begin
    unique case (addr)
      2'd0:    rdata = a_in ? (hs_in ? hold_a : pa_in) : lat_a;
      2'd1:    rdata = b_in ? pb_in : lat_b;
      2'd2:    rdata = {ch_in ? pc_in[7:4] : lat_c[7:4], cl_in ? pc_in[3:0] : lat_c[3:0]};
      default: rdata = {1'b1, ctrl};
    endcase
  end

endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk #(
  parameter int AUX_LO = 4,
  parameter int AUX_HI = 2,
  localparam int AUX_W = AUX_LO + AUX_HI
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic [7:0]       pa_out,
  input logic [7:0]       pb_out,
  input logic [7:0]       pc_out,
  input logic [7:0]       pa_oe,
  input logic [7:0]       pb_oe,
  input logic [7:0]       pc_oe,
  input logic [AUX_W-1:0] pd_oe,
  input logic             ibf,
  input logic             obf_n,
  input logic             intr
);

  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> (rdata[7] && !rdata[2])); // R6

  AST_MODESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3 && wdata[7]) |=>
      (pa_out == 8'd0 && pb_out == 8'd0 && pc_out == 8'd0 && !intr && obf_n && !ibf)); // R3

  AST_SETRESET_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3 && !wdata[7]) |=>
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))); // R5

  AST_PD_FOLLOWS_C: assert property (@(posedge clk) disable iff (!rst_n)
    pd_oe == {{AUX_HI{pc_oe[7]}}, {AUX_LO{pc_oe[0]}}}); // R8

  AST_OBF_NO_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    !obf_n |-> !intr); // R12

  AST_BUF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ibf && !obf_n)); // R10

endmodule

bind pio_ctrl pio_ctrl_chk #(.AUX_LO(AUX_LO), .AUX_HI(AUX_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .rdata(rdata),
  .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
  .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe), .pd_oe(pd_oe),
  .ibf(ibf), .obf_n(obf_n), .intr(intr)
);

// File: tb/sim_pio_ctrl.sv
`timescale 1ns/1ps
module sim_pio_ctrl;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [5:0] pd_out, pd_oe;
  logic stb_n = 1, ack_n = 1, ibf, obf_n, intr;

  int n_cmp = 0, n_bad = 0;
  logic [6:0] m_ctrl;
  logic [7:0] m_a, m_b, m_c;

  always #4 clk = ~clk;

  pio_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0; #1;
  endtask

  task automatic m_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_a = d;
      2'd1: m_b = d;
      2'd2: m_c = d;
      default:
        if (d[7]) begin m_ctrl = {d[6:3], 1'b0, d[1:0]}; m_a = 0; m_b = 0; m_c = 0; end
        else if (!d[6]) m_c[d[3:1]] = d[0];
    endcase
    wr_reg(a, d);
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl[4] ? pa_in : m_a;
      2'd1: return m_ctrl[1] ? pb_in : m_b;
      2'd2: return {m_ctrl[3] ? pc_in[7:4] : m_c[7:4], m_ctrl[0] ? pc_in[3:0] : m_c[3:0]};
      default: return {1'b1, m_ctrl};
    endcase
  endfunction

  task automatic check_all(input string tag);
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], d);
      chk($sformatf("%s rd%0d", tag, a), d, exp_rd(a[1:0]));
    end
    chk({tag, " pa_out R4"}, pa_out, m_a);
    chk({tag, " pa_oe R4"}, pa_oe, m_ctrl[4] ? 8'h00 : 8'hFF);
    chk({tag, " pb_oe R4"}, pb_oe, m_ctrl[1] ? 8'h00 : 8'hFF);
    chk({tag, " pc_out R4"}, pc_out, m_c);
    chk({tag, " pc_oe R4"}, pc_oe, {{4{~m_ctrl[3]}}, {4{~m_ctrl[0]}}});
    chk({tag, " pd_out R8"}, {2'b0, pd_out}, {2'b0, m_c[5:4], m_c[3:0]});
    chk({tag, " pd_oe R8"}, {2'b0, pd_oe}, {2'b0, {2{~m_ctrl[3]}}, {4{~m_ctrl[0]}}});
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog R1 got hang exp done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, c;
    void'($urandom(32'h5EED));
    m_ctrl = 7'b0011011; m_a = 0; m_b = 0; m_c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R2 reset state
    chk("R2 ibf", {7'b0, ibf}, 8'h00);
    chk("R2 obf_n", {7'b0, obf_n}, 8'h01);
    chk("R2 intr", {7'b0, intr}, 8'h00);
    rd_reg(2'd3, d); chk("R2 ctrl", d, 8'h9B);
    check_all("R2");

    // R1 R3 R4 R6 R7 random simple-mode traffic
    for (int i = 0; i < 60; i++) begin
      c = 8'h80 | 8'($urandom) & 8'h7F;
      if (c[6:5] == 2'b01) c[6] = 1'b1; // R7 codes 10/11
      m_write(2'd3, c);
      chk("R3 latches cleared", pa_out | pb_out | pc_out, 8'h00);
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      m_write(2'd0, 8'($urandom));
      m_write(2'd1, 8'($urandom));
      m_write(2'd2, 8'($urandom));
      if (i % 3 == 0) m_write(2'd3, 8'($urandom) & 8'h0F); // R5
      check_all("R1_R6_R7");
      chk("R7 no handshake", {6'b0, ibf, intr}, 8'h00);
    end

    // R5 set/reset keeps mode; R8 port D mapping
    m_write(2'd3, 8'h88);
    m_write(2'd2, 8'h3C);
    chk("R8 pd_out", {2'b0, pd_out}, 8'h3C);
    chk("R8 pd_oe", {2'b0, pd_oe}, 8'h0F);
    m_write(2'd3, 8'h0F);
    m_write(2'd3, 8'h02);
    rd_reg(2'd3, d); chk("R5 ctrl kept", d, 8'h88);
    chk("R5 pc_out", pc_out, 8'hBC);
    // R9 enable write leaves C latch alone
    wr_reg(2'd3, 8'h41);
    chk("R9 pc unchanged", pc_out, 8'hBC);

    // R10 R11 handshake input
    m_write(2'd3, 8'hB0);
    wr_reg(2'd3, 8'h41);
    pa_in = 8'h5A;
    @(negedge clk); stb_n = 0;
    @(negedge clk); stb_n = 1; pa_in = 8'h33;
    @(negedge clk); #1;
    chk("R10 ibf", {7'b0, ibf}, 8'h01);
    chk("R11 intr set", {7'b0, intr}, 8'h01);
    rd_reg(2'd0, d);
    chk("R10 held value", d, 8'h5A);
    chk("R11 intr cleared", {7'b0, intr}, 8'h00);
    chk("R11 ibf cleared", {7'b0, ibf}, 8'h00);
    wr_reg(2'd3, 8'h40);
    @(negedge clk); stb_n = 0;
    @(negedge clk); stb_n = 1;
    @(negedge clk); #1;
    chk("R11 no intr w/o enable", {7'b0, intr}, 8'h00);
    chk("R10 ibf again", {7'b0, ibf}, 8'h01);

    // R12 R13 handshake output
    m_write(2'd3, 8'hA0);
    wr_reg(2'd3, 8'h41);
    m_write(2'd0, 8'hC3);
    #1;
    chk("R12 obf_n low", {7'b0, obf_n}, 8'h00);
    chk("R12 pa_out", pa_out, 8'hC3);
    @(negedge clk); ack_n = 0;
    @(negedge clk); ack_n = 1;
    @(negedge clk); #1;
    chk("R12 obf_n high", {7'b0, obf_n}, 8'h01);
    chk("R12 intr set", {7'b0, intr}, 8'h01);
    m_write(2'd0, 8'h11);
    #1;
    chk("R12 intr cleared by write", {7'b0, intr}, 8'h00);
    m_write(2'd2, 8'hF0);
    pc_in = 8'h0F;
    check_all("R13");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule